// File: doc/BRIEF.md
# Banked Host Register File

This block holds the byte-wide control registers that a host reaches through a 5-bit offset. The register space is divided into four banks of 32 byte locations. Two bits in the primary control register choose the active bank. The top five offsets bypass banking: from every bank they reach the same five shared registers. Those are interrupt enable, interrupt flags, status, secondary control and primary control, and the last of them holds the bank selector.

Bank 0 stores eleven 13-bit buffer pointers that span an 8 KB buffer space. Each pointer occupies a low byte at an even offset and a high byte at the next odd offset. Only the low five bits of each high byte exist. Bank 1 stores a small table of general filter bytes. Bank 3 holds a read-only revision register. Every other location is unimplemented: it ignores writes and reads as zero. Offset 1Ah is reserved in every bank and behaves the same way.

The host issues one access per cycle on a simple byte port. Read data is registered. The pointers leave the block on a flat vector for the engines that use them. The status byte is sampled from an input.

Top module: `bank_regfile`

## Requirements
- R1: After a synchronous reset, rdata is 00h and the pointers hold these values. Read pointer (index 0), receive start (index 4) and receive read pointer (index 6) hold 05FAh. Receive end (index 5) holds 1FFFh. All other pointers hold 0000h. Primary control holds 00h and secondary control holds 80h.
- R2: The active bank equals bits [1:0] of the primary control register at offset 1Fh. A write to that register first affects the access made in the following cycle.
- R3: Offsets 1Bh (interrupt enable), 1Ch (interrupt flags), 1Dh (status), 1Eh (secondary control) and 1Fh (primary control) reach the same registers from all four banks.
- R4: A write to an unimplemented location changes no register. A read of one returns 00h.
- R5: Offset 1Ah reads as 00h in every bank, and a write to it has no effect.
- R6: In bank 0, pointer n has its low byte at offset 2n and its high byte at offset 2n+1, for n from 0 to 10. The high byte keeps only bits [4:0], and its bits [7:5] read 0. Pointer n appears on ptr_flat[13n+12:13n].
- R7: Bit 7 of the interrupt flag register always reads 0. Bits [6:0] read back as written.
- R8: Offset 12h in bank 3 returns the REV_ID parameter (default 06h), and writes leave it unchanged.
- R9: rdata is loaded at the clock edge that samples rd_en and holds its value while rd_en is low. A read and a write to the same location in the same cycle return the old contents.
- R10: The status register at 1Dh returns status_in as sampled at the read edge, and host writes to it are ignored.
- R11: In bank 1, offsets 00h through 0Fh are read/write table bytes that reset to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 5 | Offset within the active bank |
| wdata | input | 8 | Write data |
| status_in | input | 8 | Live status byte shown at offset 1Dh |
| rdata | output | 8 | Registered read data |
| cur_bank | output | 2 | Active bank number |
| ptr_flat | output | 143 | Eleven 13-bit buffer pointers, pointer 0 in the low bits |

## Verification
A write takes effect at the edge that samples wr_en, and so does a bank change. A read result is loaded into rdata at the edge that samples rd_en. The bench therefore applies inputs on the falling edge, lets one rising edge pass, and compares rdata, cur_bank and ptr_flat on the following falling edge. A bank switch is checked on the access made in the cycle after the write to 1Fh. The same-cycle read-and-write case is checked against the contents held before that edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_PTR    = 3'd1,
    RG_TBL    = 3'd2,
    RG_REV    = 3'd3,
    RG_COMMON = 3'd4
  } region_e;

  localparam int unsigned NUM_COMMON = 5;
  localparam int unsigned NUM_BANKS  = 4;

  // Common register slots, counted upward from the first shared offset.
  localparam logic [2:0] CM_IE     = 3'd0;
  localparam logic [2:0] CM_FLAGS  = 3'd1;
  localparam logic [2:0] CM_STATUS = 3'd2;
  localparam logic [2:0] CM_CTRL2  = 3'd3;
  localparam logic [2:0] CM_CTRL1  = 3'd4;

  // Reset value of each pointer (16 bits wide, sliced by the user).
  function automatic logic [15:0] ptr_reset(input int idx);
    case (idx)
      0, 4, 6: ptr_reset = 16'h05FA;
      5:       ptr_reset = 16'h1FFF;
      default: ptr_reset = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/rf_decode.sv
module rf_decode
  import rf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_PTR   = 11,
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned REV_OFS   = 18,
  localparam int unsigned PIDX_W   = $clog2(NUM_PTR),
  localparam int unsigned TIDX_W   = $clog2(TBL_DEPTH),
  localparam int unsigned LOCS     = 1 << ADDR_W,
  localparam int unsigned COM_BASE = LOCS - NUM_COMMON
) (
  input  logic [1:0]        bank,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PIDX_W-1:0] ptr_idx,
  output logic              ptr_hi,
  output logic [TIDX_W-1:0] tbl_idx,
  output logic [2:0]        com_idx
);

  logic [ADDR_W-1:0] com_off;

  assign ptr_idx = PIDX_W'(addr >> 1);
  assign ptr_hi  = addr[0];
  assign tbl_idx = addr[TIDX_W-1:0];
  assign com_off = addr - ADDR_W'(COM_BASE);
  assign com_idx = com_off[2:0];

  always_comb begin
    region = RG_NONE;
    if (32'(addr) >= COM_BASE) begin
      region = RG_COMMON;
    end else if (bank == 2'd0 && 32'(addr) < 2 * NUM_PTR) begin
      region = RG_PTR;
    end else if (bank == 2'd1 && 32'(addr) < TBL_DEPTH) begin
      region = RG_TBL;
    end else if (bank == 2'd3 && 32'(addr) == REV_OFS) begin
      region = RG_REV;
    end
  end

endmodule

// File: rtl/rf_ptr_file.sv
module rf_ptr_file
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PTR_W   = 13,
  parameter int unsigned NUM_PTR = 11,
  localparam int unsigned PIDX_W = $clog2(NUM_PTR),
  localparam int unsigned HI_W   = PTR_W - DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [PIDX_W-1:0]        idx,
  input  logic                     hi,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rd_byte,
  output logic [NUM_PTR*PTR_W-1:0] ptr_flat
);

  logic [PTR_W-1:0] ptr_q [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    localparam logic [15:0] RST16 = ptr_reset(g);
    localparam logic [PTR_W-1:0] RSTV = RST16[PTR_W-1:0];
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= RSTV;
      end else if (wr && 32'(idx) == g) begin
        if (hi) ptr_q[g][PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
        else    ptr_q[g][DATA_W-1:0]     <= wdata;
      end
    end
    assign ptr_flat[g*PTR_W +: PTR_W] = ptr_q[g];
  end

  always_comb begin
    rd_byte = '0;
    if (32'(idx) < NUM_PTR) begin
      if (hi) rd_byte = DATA_W'(ptr_q[idx][PTR_W-1:DATA_W]);
      else    rd_byte = ptr_q[idx][DATA_W-1:0];
    end
  end

endmodule

// File: rtl/rf_table.sv
module rf_table #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned TIDX_W   = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [TIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte
);

  logic [DATA_W-1:0] mem [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                          mem[g] <= '0;
      else if (wr && 32'(idx) == g)     mem[g] <= wdata;
    end
  end

  assign rd_byte = mem[idx];

endmodule

// File: rtl/rf_common.sv
module rf_common
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  CTRL2_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rd_byte,
  output logic [1:0]        bank
);

  logic [DATA_W-1:0] ie_q, flags_q, ctrl2_q, ctrl1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= '0;
      flags_q <= '0;
      ctrl2_q <= DATA_W'(CTRL2_RST);
      ctrl1_q <= '0;
    end else if (wr) begin
      case (idx)
        CM_IE:    ie_q    <= wdata;
        CM_FLAGS: flags_q <= {1'b0, wdata[DATA_W-2:0]};
        CM_CTRL2: ctrl2_q <= wdata;
        CM_CTRL1: ctrl1_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      CM_IE:     rd_byte = ie_q;
      CM_FLAGS:  rd_byte = flags_q;
      CM_STATUS: rd_byte = status_in;
      CM_CTRL2:  rd_byte = ctrl2_q;
      CM_CTRL1:  rd_byte = ctrl1_q;
      default:   rd_byte = '0;
    endcase
  end

  assign bank = ctrl1_q[1:0];

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import rf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PTR_W     = 13,
  parameter int unsigned NUM_PTR   = 11,
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned REV_OFS   = 18,
  parameter logic [7:0]  REV_ID    = 8'h06,
  localparam int unsigned PIDX_W   = $clog2(NUM_PTR),
  localparam int unsigned TIDX_W   = $clog2(TBL_DEPTH),
  localparam int unsigned PF_W     = NUM_PTR * PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        cur_bank,
  output logic [PF_W-1:0]   ptr_flat
);

  region_e           region;
  logic [PIDX_W-1:0] ptr_idx;
  logic              ptr_hi;
  logic [TIDX_W-1:0] tbl_idx;
  logic [2:0]        com_idx;
  logic [DATA_W-1:0] ptr_byte, tbl_byte, com_byte, rd_mux;

  rf_decode #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR),
    .TBL_DEPTH(TBL_DEPTH), .REV_OFS(REV_OFS)
  ) u_dec (
    .bank(cur_bank), .addr(addr), .region(region),
    .ptr_idx(ptr_idx), .ptr_hi(ptr_hi),
    .tbl_idx(tbl_idx), .com_idx(com_idx)
  );

  rf_ptr_file #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .NUM_PTR(NUM_PTR)
  ) u_ptr (
    .clk(clk), .rst(rst), .wr(wr_en && region == RG_PTR),
    .idx(ptr_idx), .hi(ptr_hi), .wdata(wdata),
    .rd_byte(ptr_byte), .ptr_flat(ptr_flat)
  );

  rf_table #(
    .DATA_W(DATA_W), .TBL_DEPTH(TBL_DEPTH)
  ) u_tbl (
    .clk(clk), .rst(rst), .wr(wr_en && region == RG_TBL),
    .idx(tbl_idx), .wdata(wdata), .rd_byte(tbl_byte)
  );

  rf_common #(
    .DATA_W(DATA_W), .CTRL2_RST(8'h80)
  ) u_com (
    .clk(clk), .rst(rst), .wr(wr_en && region == RG_COMMON),
    .idx(com_idx), .wdata(wdata), .status_in(status_in),
    .rd_byte(com_byte), .bank(cur_bank)
  );

  always_comb begin
    case (region)
      RG_PTR:    rd_mux = ptr_byte;
      RG_TBL:    rd_mux = tbl_byte;
      RG_REV:    rd_mux = DATA_W'(REV_ID);
      RG_COMMON: rd_mux = com_byte;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter logic [7:0] REV_ID = 8'h06
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic [4:0]   addr,
  input logic [7:0]   wdata,
  input logic [7:0]   rdata,
  input logic [1:0]   cur_bank,
  input logic [142:0] ptr_flat
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cur_bank == 2'd0 && rdata == 8'h00 &&
                    ptr_flat[12:0] == 13'h05FA && ptr_flat[77:65] == 13'h1FFF));

  a_r2_bank_follow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'h1F) |=> cur_bank == $past(wdata[1:0]));

  a_r2_bank_keep: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 5'h1F) |=> $stable(cur_bank));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'h1A) |=> rdata == 8'h00);

  a_r6_hi_top_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_bank == 2'd0 && addr <= 5'h15 && addr[0]) |=> rdata[7:5] == 3'b000);

  a_r7_flag_msb: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'h1C) |=> !rdata[7]);

  a_r8_revision: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_bank == 2'd3 && addr == 5'h12) |=> rdata == REV_ID);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind bank_regfile rf_checker #(.REV_ID(REV_ID)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cur_bank(cur_bank), .ptr_flat(ptr_flat)
);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [4:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   status_in = '0;
  logic [7:0]   rdata;
  logic [1:0]   cur_bank;
  logic [142:0] ptr_flat;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bank_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_in(status_in), .rdata(rdata),
    .cur_bank(cur_bank), .ptr_flat(ptr_flat)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, 16'(rdata), 16'(exp));
  endtask

  task automatic set_bank(input logic [1:0] b);
    wr(5'h1F, {6'b0, b});
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", 16'(rdata), 16'h00);
    check("R2 bank after reset", 16'(cur_bank), 16'h0);
    rd(5'h00, 8'hFA, "R1 read ptr lo");
    rd(5'h01, 8'h05, "R1 read ptr hi");
    rd(5'h02, 8'h00, "R1 write ptr lo");
    rd(5'h08, 8'hFA, "R1 rx start lo");
    rd(5'h0B, 8'h1F, "R1 rx end hi");
    rd(5'h0C, 8'hFA, "R1 rx rd ptr lo");
    rd(5'h0D, 8'h05, "R1 rx rd ptr hi");
    rd(5'h1E, 8'h80, "R1 ctrl2 reset");
    rd(5'h1F, 8'h00, "R1 ctrl1 reset");
    check("R1 ptr5 flat", 16'(ptr_flat[5*13 +: 13]), 16'h1FFF);
  endtask

  task automatic t_pointer();
    wr(5'h02, 8'h34);
    wr(5'h03, 8'hFF);
    rd(5'h03, 8'h1F, "R6 high byte top bits zero");
    rd(5'h02, 8'h34, "R6 low byte");
    check("R6 ptr1 on flat", 16'(ptr_flat[1*13 +: 13]), 16'h1F34);
    wr(5'h15, 8'h0A);
    rd(5'h15, 8'h0A, "R6 last pointer high");
    check("R6 ptr10 on flat", 16'(ptr_flat[10*13 +: 13]), 16'h0A00);
  endtask

  task automatic t_common();
    set_bank(2'd2);
    check("R2 bank now 2", 16'(cur_bank), 16'h2);
    wr(5'h1B, 8'hA5);
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      rd(5'h1B, 8'hA5, "R3 irq enable shared");
    end
    wr(5'h1C, 8'hFF);
    rd(5'h1C, 8'h7F, "R7 flag msb reads 0");
    set_bank(2'd1);
    rd(5'h1C, 8'h7F, "R3 flags from bank1");
    wr(5'h1E, 8'h5C);
    set_bank(2'd0);
    rd(5'h1E, 8'h5C, "R3 ctrl2 shared");
  endtask

  task automatic t_unimpl();
    set_bank(2'd0);
    wr(5'h16, 8'h55);
    rd(5'h16, 8'h00, "R4 bank0 16h reads 0");
    set_bank(2'd2);
    wr(5'h00, 8'h77);
    rd(5'h00, 8'h00, "R4 bank2 00h reads 0");
    set_bank(2'd0);
    rd(5'h00, 8'hFA, "R4 bank0 00h not aliased");
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      wr(5'h1A, 8'hFF);
      rd(5'h1A, 8'h00, "R5 reserved 1Ah");
    end
    rd(5'h1B, 8'hA5, "R5 write to 1Ah no effect");
    rd(5'h1F, 8'h03, "R5 ctrl1 unchanged");
  endtask

  task automatic t_bank_switch();
    set_bank(2'd1);
    wr(5'h00, 8'h22);
    wr(5'h0F, 8'h9E);
    rd(5'h0F, 8'h9E, "R11 table last entry");
    rd(5'h05, 8'h00, "R11 table reset");
    set_bank(2'd0);
    wr(5'h00, 8'h11);
    rd(5'h00, 8'h11, "R2 bank0 after switch");
    set_bank(2'd1);
    rd(5'h00, 8'h22, "R2 bank1 next access");
  endtask

  task automatic t_revision();
    set_bank(2'd3);
    rd(5'h12, 8'h06, "R8 revision value");
    wr(5'h12, 8'h00);
    rd(5'h12, 8'h06, "R8 revision ignores write");
  endtask

  task automatic t_status();
    status_in = 8'hC3;
    rd(5'h1D, 8'hC3, "R10 status reads input");
    wr(5'h1D, 8'h00);
    rd(5'h1D, 8'hC3, "R10 status ignores write");
    status_in = 8'h18;
    rd(5'h1D, 8'h18, "R10 status follows input");
  endtask

  task automatic t_read_timing();
    rd(5'h1B, 8'hA5, "R9 read before hold");
    repeat (3) @(negedge clk);
    check("R9 rdata held", 16'(rdata), 16'hA5);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 5'h1B; wdata = 8'h3C;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R9 same-cycle read returns old", 16'(rdata), 16'hA5);
    rd(5'h1B, 8'h3C, "R9 write landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_common();
    t_unimpl();
    t_bank_switch();
    t_revision();
    t_status();
    t_read_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule